// File: doc/BRIEF.md
# Signed Decimal Text Line Serializer

This block turns one signed crossing sample into a fixed-width line of text and shifts it out on an asynchronous serial line. A sample is a direction flag plus a 16-bit magnitude, so the values run from -65535 to +65535. The block converts the magnitude to five decimal digits and puts a sign character in front. A carriage return and a line feed close the line, so every line is eight characters long. Each character goes out as a 10-bit frame: one start bit, eight data bits and one stop bit, with no parity.

Samples arrive on a valid/ready input. A transfer takes place on a rising clock edge where `s_valid` and `s_ready` are both high. `s_ready` stays high only while the block is idle. It goes low at the accepting edge and stays low until the stop bit of the line feed has been sent. The producer has to hold its sample while it waits. Nothing is buffered inside the block, so back-pressure lasts for one whole line. The bit period is `CLK_HZ / BAUD` clock cycles. The defaults give 115,200 baud from a 50 MHz clock.

Top module: `lc_text_serializer`

## Requirements
- R1: After reset `txd` is high, `busy` is low and `s_ready` is high. `txd` stays high whenever `busy` is low.
- R2: A sample is taken on an edge with `s_valid` and `s_ready` both high. `busy` is high from the next cycle. While `busy` is high, `s_ready` is low and `s_valid` has no effect on the line being sent.
- R3: The first character is `+` (0x2B) when `s_dir` is 1, meaning an upward crossing. It is `-` (0x2D) when `s_dir` is 0.
- R4: Characters 2 to 6 are the decimal digits of `s_mag`, most significant first, as ASCII 0x30 to 0x39. Leading zeros are kept, so 7 is sent as `00007`.
- R5: Character 7 is carriage return (0x0D) and character 8 is line feed (0x0A).
- R6: Each character is a frame made of a low start bit, then eight data bits with the least significant bit first, then a high stop bit. Every bit lasts `CLK_HZ/BAUD` cycles.
- R7: The eight frames follow each other with no idle gap. The binary-to-decimal conversion finishes before the first start bit. `busy` falls exactly 80 bit periods after the sign character's start bit begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample offered |
| s_ready | output | 1 | Block can take a sample (high when idle) |
| s_dir | input | 1 | Crossing direction, 1 = up (`+`), 0 = down (`-`) |
| s_mag | input | 16 | Sample magnitude |
| busy | output | 1 | A line is being converted or sent |
| txd | output | 1 | Serial output, idles high |

## Verification
The hardest case to reach is a producer that keeps `s_valid` high with a different sample while a line is still being sent. The bench raises `s_valid` with unrelated data right after an accept and keeps it there through six characters. It checks that `s_ready` stays low for that whole time and that the line on the wire still carries the first sample. It also drops `s_valid` before `busy` falls, so the stray sample is never taken. Digit boundaries (9/10, 99/100, 9999/10000, 0 and 65535) and a stride sweep over the magnitude range are decoded bit by bit at the centre of each bit.

// File: rtl/lc_text_pkg.sv
package lc_text_pkg;
  localparam logic [7:0] CH_PLUS  = 8'h2B;
  localparam logic [7:0] CH_MINUS = 8'h2D;
  localparam logic [7:0] CH_ZERO  = 8'h30;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_LF    = 8'h0A;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_SEND = 2'd2
  } ser_state_t;
endpackage

// File: rtl/lc_bcd_conv.sv
module lc_bcd_conv #(
  parameter int MAG_W  = 16,
  parameter int DIGITS = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [MAG_W-1:0]      mag,
  output logic                  done,
  output logic [4*DIGITS-1:0]   bcd
);
  localparam int CNT_W = $clog2(MAG_W + 1);

  logic [MAG_W-1:0]    sh;
  logic [4*DIGITS-1:0] adj;
  logic [CNT_W-1:0]    cnt;
  logic                run;

  // Add-three correction on every decimal nibble before each shift
  for (genvar d = 0; d < DIGITS; d++) begin : g_adj
    always_comb begin
      if (bcd[4*d +: 4] >= 4'd5) adj[4*d +: 4] = bcd[4*d +: 4] + 4'd3;
      else                       adj[4*d +: 4] = bcd[4*d +: 4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      bcd  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sh  <= mag;
        bcd <= '0;
        cnt <= CNT_W'(MAG_W);
        run <= 1'b1;
      end else if (run) begin
        bcd <= {adj[4*DIGITS-2:0], sh[MAG_W-1]};
        sh  <= sh << 1;
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  for (genvar d = 0; d < DIGITS; d++) begin : g_chk
    assert_digit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (bcd[4*d +: 4] <= 4'd9));
  end
endmodule

// File: rtl/lc_uart_tx.sv
module lc_uart_tx #(
  parameter int DIV = 434
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] data,
  output logic       done,
  output logic       txd
);
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [8:0]       sh;
  logic [3:0]       left;
  logic [DIV_W-1:0] div_cnt;
  logic             active;

  // High in the last cycle of the stop bit; a new start may be taken then
  assign done = active && (div_cnt == '0) && (left == 4'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '1;
      left    <= '0;
      div_cnt <= '0;
      active  <= 1'b0;
      txd     <= 1'b1;
    end else if (start && (!active || done)) begin
      txd     <= 1'b0;
      sh      <= {1'b1, data};
      left    <= 4'd9;
      div_cnt <= DIV_W'(DIV - 1);
      active  <= 1'b1;
    end else if (active) begin
      if (div_cnt == '0) begin
        if (left == 4'd0) begin
          active <= 1'b0;
        end else begin
          txd     <= sh[0];
          sh      <= {1'b1, sh[8:1]};
          left    <= left - 1'b1;
          div_cnt <= DIV_W'(DIV - 1);
        end
      end else begin
        div_cnt <= div_cnt - 1'b1;
      end
    end
  end

  assert_start_when_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!active || done));
  assert_frame_opens_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !$past(active)) |-> !txd);
  assert_stop_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> txd);
endmodule

// File: rtl/lc_text_serializer.sv
module lc_text_serializer
  import lc_text_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 115_200,
  parameter int MAG_W  = 16,
  parameter int DIGITS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic             s_dir,
  input  logic [MAG_W-1:0] s_mag,
  output logic             busy,
  output logic             txd
);
  localparam int DIV   = CLK_HZ / BAUD;
  localparam int NCH   = DIGITS + 3;
  localparam int IDX_W = $clog2(NCH);

  ser_state_t          state;
  logic [IDX_W-1:0]    idx;
  logic                dir_q;
  logic                conv_done;
  logic [4*DIGITS-1:0] bcd;
  logic                tx_start;
  logic                tx_done;
  logic [IDX_W-1:0]    next_idx;
  logic [7:0]          tx_char;
  logic                accept;

  function automatic logic [7:0] char_at(input logic [IDX_W-1:0] k,
                                         input logic up,
                                         input logic [4*DIGITS-1:0] dig);
    logic [7:0] c;
    c = CH_LF;
    if (k == '0) c = up ? CH_PLUS : CH_MINUS;
    for (int i = 1; i <= DIGITS; i++)
      if (k == IDX_W'(i)) c = CH_ZERO + {4'd0, dig[4*(DIGITS-i) +: 4]};
    if (k == IDX_W'(DIGITS + 1)) c = CH_CR;
    return c;
  endfunction

  assign s_ready  = (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);
  assign accept   = s_valid && s_ready;
  assign next_idx = (state == ST_CONV) ? '0 : idx + 1'b1;
  assign tx_start = ((state == ST_CONV) && conv_done) ||
                    ((state == ST_SEND) && tx_done && (idx != IDX_W'(NCH - 1)));
  assign tx_char  = char_at(next_idx, dir_q, bcd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
      dir_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          dir_q <= s_dir;
          state <= ST_CONV;
        end
        ST_CONV: if (conv_done) begin
          idx   <= '0;
          state <= ST_SEND;
        end
        ST_SEND: if (tx_done) begin
          if (idx == IDX_W'(NCH - 1)) state <= ST_IDLE;
          else                        idx   <= next_idx;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  lc_bcd_conv #(.MAG_W(MAG_W), .DIGITS(DIGITS)) u_conv (
    .clk(clk), .rst_n(rst_n), .start(accept), .mag(s_mag),
    .done(conv_done), .bcd(bcd)
  );

  lc_uart_tx #(.DIV(DIV)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .data(tx_char),
    .done(tx_done), .txd(txd)
  );

  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  assert_accept_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  assert_conv_only_when_converting_R7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> (state == ST_CONV));
endmodule

// File: tb/lc_text_serializer_bench.sv
module lc_text_serializer_bench;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_dir = 1'b0;
  logic [15:0] s_mag = '0;
  logic        s_ready, busy, txd;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lc_text_serializer #(.CLK_HZ(460_800), .BAUD(115_200)) u_lc_text_serializer (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_dir(s_dir), .s_mag(s_mag), .busy(busy), .txd(txd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_char(input int k, input logic up, input int m);
    int p;
    if (k == 0) return up ? 8'h2B : 8'h2D;
    if (k == 6) return 8'h0D;
    if (k == 7) return 8'h0A;
    p = 1;
    for (int j = 0; j < 5 - k; j++) p = p * 10;
    return 8'h30 + 8'((m / p) % 10);
  endfunction

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_line(input logic up, input int m, input bit noisy);
    int t0;
    logic [7:0] ch;
    bit rdy_bad;
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    s_valid = 1'b1; s_dir = up; s_mag = 16'(m);
    @(negedge clk);
    check("R2 busy after accept", {31'd0, busy}, 32'd1);
    if (noisy) begin
      s_dir = ~up; s_mag = 16'(m ^ 16'h5A5A);
    end else s_valid = 1'b0;
    rdy_bad = 1'b0;
    t0 = 0;
    for (int k = 0; k < 8; k++) begin
      while (txd) begin
        if (s_ready) rdy_bad = 1'b1;
        @(negedge clk);
      end
      if (k == 0) t0 = cyc;
      nclk(DIV / 2);
      check("R6 start bit low", {31'd0, txd}, 32'd0);
      for (int b = 0; b < 8; b++) begin
        nclk(DIV);
        ch[b] = txd;
        if (s_ready) rdy_bad = 1'b1;
      end
      nclk(DIV);
      check("R6 stop bit high", {31'd0, txd}, 32'd1);
      if (k == 0) check("R3 sign char", {24'd0, ch}, {24'd0, exp_char(k, up, m)});
      else if (k < 6) check("R4 digit char", {24'd0, ch}, {24'd0, exp_char(k, up, m)});
      else check("R5 line end char", {24'd0, ch}, {24'd0, exp_char(k, up, m)});
      if (k == 5) s_valid = 1'b0;
      if (k < 7) begin
        nclk(DIV - DIV / 2);
        check("R7 no gap between frames", {31'd0, txd}, 32'd0);
      end
    end
    while (busy) @(negedge clk);
    check("R7 busy falls after 80 bit periods", 32'(cyc - t0), 32'(80 * DIV));
    check("R1 line high when idle", {31'd0, txd}, 32'd1);
    if (noisy) check("R2 ready low while busy", {31'd0, rdy_bad}, 32'd0);
  endtask

  initial begin
    nclk(3);
    check("R1 txd after reset", {31'd0, txd}, 32'd1);
    check("R1 busy after reset", {31'd0, busy}, 32'd0);
    check("R1 ready after reset", {31'd0, s_ready}, 32'd1);
    rst_n = 1'b1;
    nclk(2);
    run_line(1'b1, 0, 1'b0);
    run_line(1'b0, 65535, 1'b0);
    run_line(1'b1, 9, 1'b0);
    run_line(1'b0, 10, 1'b0);
    run_line(1'b1, 99, 1'b0);
    run_line(1'b0, 100, 1'b0);
    run_line(1'b1, 9999, 1'b0);
    run_line(1'b0, 10000, 1'b0);
    run_line(1'b1, 12345, 1'b1);
    run_line(1'b0, 54321, 1'b1);
    for (int i = 0; i < 16; i++) run_line(1'(i), (i * 4099 + 7) % 65536, 1'(i % 3 == 0));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL R7 watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule